// File: doc/BRIEF.md
# Delta modulation output unit

This block turns a stream of sample bytes into a 7-bit audio level. A programmable-rate timer sets the pace. On each timer expiry the level moves up or down by two, following one bit of the current byte, lowest bit first. After eight expiries the unit takes the next byte from a one-byte read buffer owned by a separate fetch controller. It tells that controller the byte was taken with a one-cycle consume strobe.

If the buffer is empty when a new byte is due, the unit goes silent for the next eight expiries and the level holds. A register write can load the level directly at any time. Mixing, filtering and memory fetch are handled elsewhere.

Top module: `dmod_output_unit`

## Requirements
- R1: After reset the level is 0 and the consume strobe is low. The unit starts silent, so an idle unit with an empty buffer keeps level 0.
- R2: The rate index selects the expiry period in clock cycles. Index 0 gives 428, then 380, 340, 320, 286, 254, 226, 214, 190, 160, 142, 128, 106, 84, 72, and index 15 gives 54. Consecutive consume strobes during continuous playback are 8 periods apart.
- R3: A change of the rate index takes effect only at the next timer reload. The period already running completes at the old length.
- R4: On an expiry that is not silent, bit 0 of the shift register decides the step. If the bit is 1, the level rises by 2 when it is at most 125 and holds otherwise. If the bit is 0, the level falls by 2 when it is at least 2 and holds otherwise. The shift register then moves right, so byte bits are used from bit 0 up to bit 7.
- R5: Each byte covers exactly eight expiries. The bit counter reloads to 8 on an expiry when it reads 0 or 1, and that expiry begins a new output cycle.
- R6: If the buffer is empty when a new output cycle begins, the unit is silent for that cycle. The level then holds and no consume strobe is issued.
- R7: If the buffer holds a byte when a new output cycle begins, the byte loads into the shift register and silence clears. The consume strobe is high for exactly one cycle, in the cycle after the loading clock edge.
- R8: A direct level write loads bits 6:0 of the write data into the level on the next edge. It overrides a step that lands on the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| rate_sel_i | input | 4 | Rate index into the period table |
| lvl_wr_i | input | 1 | Direct level write strobe |
| lvl_wr_data_i | input | 8 | Direct level write data; bits 6:0 used |
| buf_byte_i | input | 8 | Sample byte held in the read buffer |
| buf_empty_i | input | 1 | Read buffer holds no byte |
| level_o | output | 7 | Audio output level |
| consume_o | output | 1 | One-cycle pulse: buffer byte taken |

## Verification
The bench builds the unit with its default widths: a 7-bit level, an 8-bit shift register and a step of 2. It runs the full period table, so it can check every one of the 16 rates against measured spacing between consume strobes.

At the fastest rate a byte lasts only 432 cycles. That lets the bench run several byte patterns and drive both saturation edges (125 to 127, and 3 to 1). It also lines up a direct write with a step on the same edge and changes the rate part-way through a running period.

// File: rtl/dmod_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and the expiry period table for the delta
// modulation output unit. Assumes a 4-bit rate index.
package dmod_pkg;
    localparam int RATE_W  = 4;
    localparam int TIMER_W = 9;   // wide enough for the longest period (428)

    // Returns the expiry period, in clock cycles, for a rate index.
    function automatic logic [TIMER_W-1:0] rate_period(input logic [RATE_W-1:0] idx);
        logic [TIMER_W-1:0] p;
        case (idx)
            4'd0:  p = 9'd428;
            4'd1:  p = 9'd380;
            4'd2:  p = 9'd340;
            4'd3:  p = 9'd320;
            4'd4:  p = 9'd286;
            4'd5:  p = 9'd254;
            4'd6:  p = 9'd226;
            4'd7:  p = 9'd214;
            4'd8:  p = 9'd190;
            4'd9:  p = 9'd160;
            4'd10: p = 9'd142;
            4'd11: p = 9'd128;
            4'd12: p = 9'd106;
            4'd13: p = 9'd84;
            4'd14: p = 9'd72;
            default: p = 9'd54;
        endcase
        return p;
    endfunction
endpackage

// File: rtl/dmod_rate_timer.sv
`timescale 1ns/1ps
// Rate timer: a down-counter that pulses tick_o when it reads zero and then
// reloads with the selected period minus one. The rate index is sampled only
// at reload. Assumes every table period is at least 2.
module dmod_rate_timer
    import dmod_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [RATE_W-1:0] rate_sel_i,
    output logic              tick_o
);
    logic [TIMER_W-1:0] cnt_q;

    assign tick_o = (cnt_q == '0);

    // Count down; on expiry reload from the period table.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (tick_o) begin
            cnt_q <= rate_period(rate_sel_i) - TIMER_W'(1);
        end else begin
            cnt_q <= cnt_q - TIMER_W'(1);
        end
    end

    // R2
    timer_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= TIMER_W'(427));

    // R3
    no_double_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
endmodule

// File: rtl/dmod_bit_sequencer.sv
`timescale 1ns/1ps
// Bit sequencer: holds the shift register, the bits-left counter and the
// silence flag. Emits one step request per non-silent expiry and takes a new
// byte from the read buffer at each output-cycle boundary. Assumes the fetch
// controller clears its buffer on consume_o.
module dmod_bit_sequencer #(
    parameter int SHIFT_W = 8
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               tick_i,
    input  logic [SHIFT_W-1:0] buf_byte_i,
    input  logic               buf_empty_i,
    output logic               step_en_o,
    output logic               step_up_o,
    output logic               consume_o
);
    localparam int CNT_W = $clog2(SHIFT_W + 1);

    logic [SHIFT_W-1:0] shift_q;
    logic [CNT_W-1:0]   bits_q;
    logic               silent_q;
    logic               boundary;

    assign boundary  = (bits_q <= CNT_W'(1));
    assign step_en_o = tick_i && !silent_q;
    assign step_up_o = shift_q[0];

    // Shift out bits and start a new output cycle on the boundary expiry.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            shift_q   <= '0;
            bits_q    <= '0;
            silent_q  <= 1'b1;
            consume_o <= 1'b0;
        end else begin
            consume_o <= 1'b0;
            if (tick_i) begin
                if (!silent_q) shift_q <= shift_q >> 1;
                if (boundary) begin
                    bits_q <= CNT_W'(SHIFT_W);
                    if (buf_empty_i) begin
                        silent_q <= 1'b1;
                    end else begin
                        silent_q  <= 1'b0;
                        shift_q   <= buf_byte_i;
                        consume_o <= 1'b1;
                    end
                end else begin
                    bits_q <= bits_q - CNT_W'(1);
                end
            end
        end
    end

    // R7
    consume_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        consume_o |=> !consume_o);

    // R7
    consume_unsilent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        consume_o |-> !silent_q);

    // R5
    bits_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bits_q <= CNT_W'(SHIFT_W));

    // R6
    empty_no_consume_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && buf_empty_i) |=> !consume_o);
endmodule

// File: rtl/dmod_level_acc.sv
`timescale 1ns/1ps
// Level accumulator: the output level register. Steps by +/-STEP with
// saturation, or takes a direct write, which wins over a step on the same
// edge. Assumes WR_W > LEVEL_W.
module dmod_level_acc #(
    parameter int LEVEL_W = 7,
    parameter int WR_W    = 8,
    parameter int STEP    = 2
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               step_en_i,
    input  logic               step_up_i,
    input  logic               ld_i,
    input  logic [WR_W-1:0]    ld_val_i,
    output logic [LEVEL_W-1:0] level_o
);
    localparam int LVL_MAX = (1 << LEVEL_W) - 1;
    localparam logic [LEVEL_W-1:0] UP_LIMIT = LEVEL_W'(LVL_MAX - STEP);
    localparam logic [LEVEL_W-1:0] STEP_V   = LEVEL_W'(STEP);

    // Apply a direct load or a saturating step.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            level_o <= '0;
        end else if (ld_i) begin
            level_o <= ld_val_i[LEVEL_W-1:0];
        end else if (step_en_i) begin
            if (step_up_i) begin
                if (level_o <= UP_LIMIT) level_o <= level_o + STEP_V;
            end else begin
                if (level_o >= STEP_V) level_o <= level_o - STEP_V;
            end
        end
    end

    // R8
    direct_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ld_i |=> level_o == $past(ld_val_i[LEVEL_W-1:0]));

    // R4
    step_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_en_i && !ld_i) |=> (int'(level_o) == int'($past(level_o))) ||
            (int'(level_o) == int'($past(level_o)) + STEP) ||
            (int'(level_o) == int'($past(level_o)) - STEP));

    // R6
    hold_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!step_en_i && !ld_i) |=> $stable(level_o));
endmodule

// File: rtl/dmod_output_unit.sv
`timescale 1ns/1ps
// Delta modulation output unit: rate timer, bit sequencer and level
// accumulator wired together. Assumes an external fetch controller keeps
// the one-byte read buffer and clears it on consume_o.
module dmod_output_unit
    import dmod_pkg::*;
#(
    parameter int LEVEL_W = 7,
    parameter int SHIFT_W = 8,
    parameter int WR_W    = 8,
    parameter int STEP    = 2
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [RATE_W-1:0]  rate_sel_i,
    input  logic               lvl_wr_i,
    input  logic [WR_W-1:0]    lvl_wr_data_i,
    input  logic [SHIFT_W-1:0] buf_byte_i,
    input  logic               buf_empty_i,
    output logic [LEVEL_W-1:0] level_o,
    output logic               consume_o
);
    logic tick;
    logic step_en;
    logic step_up;

    dmod_rate_timer u_timer (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .rate_sel_i (rate_sel_i),
        .tick_o     (tick)
    );

    dmod_bit_sequencer #(.SHIFT_W(SHIFT_W)) u_seq (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .tick_i      (tick),
        .buf_byte_i  (buf_byte_i),
        .buf_empty_i (buf_empty_i),
        .step_en_o   (step_en),
        .step_up_o   (step_up),
        .consume_o   (consume_o)
    );

    dmod_level_acc #(.LEVEL_W(LEVEL_W), .WR_W(WR_W), .STEP(STEP)) u_level (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .step_en_i (step_en),
        .step_up_i (step_up),
        .ld_i      (lvl_wr_i),
        .ld_val_i  (lvl_wr_data_i),
        .level_o   (level_o)
    );

    // R1
    reset_level_chk: assert property (@(posedge clk_i)
        !rst_ni |=> (level_o == '0) && !consume_o);
endmodule

// File: tb/dmod_output_unit_tb_top.sv
`timescale 1ns/1ps
module dmod_output_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] rate_sel = 4'd15;
    logic       lvl_wr = 1'b0;
    logic [7:0] lvl_wr_data = 8'd0;
    logic [7:0] buf_byte = 8'd0;
    logic       buf_empty = 1'b1;
    logic [6:0] level;
    logic       consume;

    always #2.5 clk = ~clk;

    dmod_output_unit dut_i (
        .clk_i(clk), .rst_ni(rst_n), .rate_sel_i(rate_sel),
        .lvl_wr_i(lvl_wr), .lvl_wr_data_i(lvl_wr_data),
        .buf_byte_i(buf_byte), .buf_empty_i(buf_empty),
        .level_o(level), .consume_o(consume)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int cons_cnt = 0;
    bit cons_prev = 1'b0;
    bit mon_en = 1'b0;
    int mon_p = 54;
    int exp_lvl = 0;
    int exp_q[$];
    string tag_q[$];
    logic [7:0] byte_q[$];

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int period_of(input int idx);
        int tbl[16] = '{428, 380, 340, 320, 286, 254, 226, 214,
                        190, 160, 142, 128, 106, 84, 72, 54};
        return tbl[idx];
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Fetch-controller model: clears the buffer on consume, refills from byte_q.
    always @(negedge clk) begin
        if (consume) begin
            cons_cnt++;
            check(!cons_prev, "R7 consume one cycle", 1, 0);
            buf_empty = 1'b1;
        end
        cons_prev = consume;
        if (buf_empty && byte_q.size() > 0) begin
            buf_byte  = byte_q.pop_front();
            buf_empty = 1'b0;
        end
    end

    // Monitor: after each consume, sample the level after every expiry.
    initial begin
        forever begin
            @(negedge clk);
            while (mon_en && consume) begin
                for (int k = 0; k < 8; k++) begin
                    repeat (mon_p) @(negedge clk);
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R7 unexpected byte", int'(level), -1);
                    end else begin
                        int e;
                        string t;
                        e = exp_q.pop_front();
                        t = tag_q.pop_front();
                        check(int'(level) == e, t, int'(level), e);
                    end
                end
            end
        end
    end

    // Driver: queue a byte and its eight expected levels (R4 rules).
    task automatic send_byte(input logic [7:0] b, input string tag);
        for (int i = 0; i < 8; i++) begin
            if (b[i]) begin
                if (exp_lvl <= 125) exp_lvl += 2;
            end else begin
                if (exp_lvl >= 2) exp_lvl -= 2;
            end
            exp_q.push_back(exp_lvl);
            tag_q.push_back(tag);
        end
        byte_q.push_back(b);
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    task automatic wr_level(input logic [7:0] v);
        @(negedge clk);
        lvl_wr = 1'b1;
        lvl_wr_data = v;
        @(negedge clk);
        lvl_wr = 1'b0;
        check(int'(level) == int'(v[6:0]), "R8 direct write low 7 bits", int'(level), int'(v[6:0]));
        exp_lvl = int'(v[6:0]);
    endtask

    task automatic wait_consume(output int t);
        @(negedge clk);
        while (!consume) @(negedge clk);
        t = cyc;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        finish_up();
    end

    initial begin
        int t0;
        int t1;
        int base;
        int held;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(level == 7'd0, "R1 reset level", int'(level), 0);
        check(!consume, "R1 reset consume", int'(consume), 0);
        base = cons_cnt;
        repeat (1000) @(negedge clk);
        // R6: idle with empty buffer stays silent
        check(level == 7'd0, "R1 idle level holds", int'(level), 0);
        check(cons_cnt == base, "R6 no consume while empty", cons_cnt, base);

        wr_level(8'hE5);
        wr_level(8'h40);

        // R4, R5, R7: continuous playback at rate 15
        mon_p = period_of(15);
        mon_en = 1'b1;
        base = cons_cnt;
        send_byte(8'hA5, "R4 pattern A5");
        send_byte(8'h3C, "R4 pattern 3C");
        send_byte(8'hFF, "R4 pattern FF");
        send_byte(8'h00, "R4 pattern 00");
        drain();
        check(cons_cnt - base == 4, "R7 one consume per byte", cons_cnt - base, 4);

        // R4: saturation edges
        wr_level(8'd125);
        send_byte(8'hFF, "R4 upper saturation");
        drain();
        check(level == 7'd127, "R4 top level", int'(level), 127);
        wr_level(8'd3);
        send_byte(8'h00, "R4 lower saturation");
        drain();
        check(level == 7'd1, "R4 bottom level", int'(level), 1);
        wr_level(8'd126);
        send_byte(8'h01, "R4 hold at 126");
        drain();

        // R6: silence holds the level
        held = int'(level);
        base = cons_cnt;
        repeat (16 * 54) @(negedge clk);
        check(int'(level) == held, "R6 silence holds level", int'(level), held);
        check(cons_cnt == base, "R6 no consume in silence", cons_cnt, base);
        mon_en = 1'b0;

        // R8: direct write wins over a step on the same edge
        wr_level(8'd0);
        byte_q.push_back(8'hFF);
        wait_consume(t0);
        repeat (53) @(negedge clk);
        lvl_wr = 1'b1;
        lvl_wr_data = 8'h50;
        @(negedge clk);
        lvl_wr = 1'b0;
        check(level == 7'h50, "R8 write beats step", int'(level), 8'h50);
        repeat (54) @(negedge clk);
        check(level == 7'h52, "R4 step after write", int'(level), 8'h52);
        repeat (8 * 54) @(negedge clk);

        // R3: rate change waits for the next reload
        wr_level(8'd0);
        byte_q.push_back(8'hFF);
        wait_consume(t0);
        repeat (10) @(negedge clk);
        rate_sel = 4'd14;
        repeat (43) @(negedge clk);
        check(level == 7'd0, "R3 old period before step", int'(level), 0);
        @(negedge clk);
        check(level == 7'd2, "R3 old period step", int'(level), 2);
        repeat (71) @(negedge clk);
        check(level == 7'd2, "R3 new period before step", int'(level), 2);
        @(negedge clk);
        check(level == 7'd4, "R3 new period step", int'(level), 4);
        repeat (8 * 72) @(negedge clk);

        // R2, R5: every table entry, measured from consume spacing
        for (int idx = 0; idx < 16; idx++) begin
            rate_sel = 4'(idx);
            byte_q.push_back(8'h55);
            byte_q.push_back(8'h55);
            wait_consume(t0);
            wait_consume(t1);
            check(t1 - t0 == 8 * period_of(idx), $sformatf("R2 R5 rate index %0d", idx),
                  t1 - t0, 8 * period_of(idx));
        end

        finish_up();
    end
endmodule